// File: doc/BRIEF.md
# Framed Serial Command Packet Receiver

This block sits behind a UART receiver and turns its stream of received bytes into command packets. Each packet is introduced by an opening marker byte and closed by a closing marker byte. Between the two come a byte count, a one-byte packet code, a payload of up to 252 bytes of arbitrary binary data, and an 8-bit checksum. Any occurrence of the opening marker value inside a packet is sent twice so that it cannot be mistaken for a new opening. The receiver removes these doubled copies, checks the count and the checksum, and hands the result to a command controller.

Payload bytes are written, in arrival order, to an external buffer through a simple write port whose address starts at zero for every packet. When a packet ends correctly, a one-cycle done strobe is raised together with the packet code and the payload length. A bad count, a checksum mismatch or a wrong closing byte raises a one-cycle error strobe that the controller uses to ask the sender for a resend. A single undoubled opening marker in the middle of a packet silently drops that packet and starts a new one.

Top module: `cmd_pkt_rx`

## Requirements
- R1: After reset is released, `pkt_done`, `err` and `wr_en` are low, and the receiver waits for an opening byte 0x01; bytes other than 0x01 received while waiting are ignored.
- R2: A packet is 0x01, count, code, payload, checksum, 0x04, where count = payload length + 3 (it covers count, code, payload and checksum) and the checksum is the 8-bit sum of count, code and all payload bytes. One cycle after the 0x04 is accepted, `pkt_done` pulses for exactly one cycle with `pkt_code` equal to the code and `pkt_len` equal to the payload length.
- R3: Every payload byte produces one write, one cycle after the byte is accepted, with `wr_data` equal to the byte and `wr_addr` equal to its position in the payload, starting at 0.
- R4: After the opening byte, any value 0x01 (count, code, payload or checksum) arrives as two consecutive 0x01 bytes and is taken as a single 0x01.
- R5: A single 0x01 inside a packet followed by a byte other than 0x01 abandons the current packet without raising `pkt_done` or `err`; that following byte is the count of a new packet, whose writes start again at address 0.
- R6: If the received checksum differs from the computed sum, `err` pulses one cycle after the checksum byte, no `pkt_done` follows, and the receiver waits for the next 0x01.
- R7: If the byte after a correct checksum is not 0x04, `err` pulses one cycle later, no `pkt_done` follows, and the receiver waits for the next 0x01.
- R8: A count below 3 makes `err` pulse one cycle after the count byte; bytes up to the next 0x01 are then ignored.
- R9: A payload of 252 bytes (count 255) is accepted; write addresses never exceed 251.
- R10: `pkt_done` and `err` are never high in the same cycle, and `pkt_done` is never high in two consecutive cycles.
- R11: Cycles with `rx_valid` low leave the state unchanged and produce no write, done or error in the following cycle; packets spread over idle gaps decode as if sent back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received byte is present on `rx_data` this cycle |
| rx_data | input | 8 | Received byte |
| wr_en | output | 1 | Payload write strobe |
| wr_addr | output | ADDR_W | Payload write address (position in packet) |
| wr_data | output | 8 | Payload byte to write |
| pkt_code | output | 8 | Code of the last completed packet |
| pkt_len | output | ADDR_W | Payload length of the last completed packet |
| pkt_done | output | 1 | One-cycle strobe: packet received correctly |
| err | output | 1 | One-cycle strobe: bad count, checksum or closing byte, resend wanted |

## Verification
The bench builds the receiver with its default parameters: markers 0x01 and 0x04, a minimum count of 3 and an 8-bit write address. With these values a count byte of 255 gives the full 252-byte payload, so the top write address 251 and the largest length are reached, while counts of 0, 1 and 2 reach the length rejection, including a count of 1 that itself arrives doubled. A checksum that works out to 0x01 and a code of 0x01 exercise unstuffing on every field that can carry that value.

// File: rtl/cmd_pkt_rx.sv
module cmd_pkt_rx #(
  parameter logic [7:0] SOF       = 8'h01,
  parameter logic [7:0] EOF       = 8'h04,
  parameter int         MIN_COUNT = 3,
  parameter int         ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [7:0]        pkt_code,
  output logic [ADDR_W-1:0] pkt_len,
  output logic              pkt_done,
  output logic              err
);

  localparam logic [7:0] MIN_CNT = 8'(MIN_COUNT);
  localparam int         MAX_PL  = 255 - MIN_COUNT;

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_CODE, S_PL, S_SUM, S_END} st_t;

  st_t              st;
  logic             esc;
  logic [7:0]       remain;
  logic [7:0]       sum;
  logic [7:0]       code;
  logic [ADDR_W-1:0] addr;

  wire  is_sof  = (rx_data == SOF);
  wire  restart = esc && !is_sof;
  st_t  stage;

  assign stage = restart ? S_CNT : st;

  always_ff @(posedge clk) begin
    wr_en    <= 1'b0;
    pkt_done <= 1'b0;
    err      <= 1'b0;
    if (rst) begin
      st       <= S_IDLE;
      esc      <= 1'b0;
      remain   <= '0;
      sum      <= '0;
      code     <= '0;
      addr     <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
      pkt_code <= '0;
      pkt_len  <= '0;
    end else if (rx_valid) begin
      if (st == S_IDLE) begin
        if (is_sof) begin
          st   <= S_CNT;
          esc  <= 1'b0;
          addr <= '0;
        end
      end else if (is_sof && !esc) begin
        esc <= 1'b1;
      end else begin
        esc <= 1'b0;
        case (stage)
          S_CNT: begin
            addr <= '0;
            sum  <= rx_data;
            if (rx_data < MIN_CNT) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else begin
              remain <= rx_data - MIN_CNT;
              st     <= S_CODE;
            end
          end
          S_CODE: begin
            code <= rx_data;
            sum  <= sum + rx_data;
            st   <= (remain == 8'd0) ? S_SUM : S_PL;
          end
          S_PL: begin
            wr_en   <= 1'b1;
            wr_data <= rx_data;
            wr_addr <= addr;
            addr    <= addr + 1'b1;
            sum     <= sum + rx_data;
            remain  <= remain - 8'd1;
            if (remain == 8'd1) st <= S_SUM;
          end
          S_SUM: begin
            if (rx_data != sum) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else begin
              st <= S_END;
            end
          end
          S_END: begin
            st <= S_IDLE;
            if (rx_data == EOF) begin
              pkt_done <= 1'b1;
              pkt_code <= code;
              pkt_len  <= addr;
            end else begin
              err <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pkt_done && !err && !wr_en));

  assert_done_len_R2: assert property (@(posedge clk) disable iff (rst)
    pkt_done |-> (int'(pkt_len) <= MAX_PL));

  assert_addr_range_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_addr) < MAX_PL));

  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(pkt_done && err));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> (!wr_en && !pkt_done && !err));

endmodule

// File: tb/cmd_pkt_rx_test.sv
`timescale 1ns/1ps
module cmd_pkt_rx_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] pkt_code;
  logic [7:0] pkt_len;
  logic       pkt_done;
  logic       err;

  always #2.5 clk = ~clk;

  cmd_pkt_rx uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pkt_code(pkt_code), .pkt_len(pkt_len), .pkt_done(pkt_done), .err(err)
  );

  int checks = 0;
  int fails  = 0;
  int gap    = 0;
  bit running  = 1'b0;
  bit finished = 1'b0;

  logic [15:0] wq[$];
  string       wtag[$];
  logic [16:0] eq[$];
  string       etag[$];
  logic [7:0]  pl[256];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic put_stuffed(input logic [7:0] b);
    put(b);
    if (b == 8'h01) put(b);
  endtask

  task automatic send_body(input logic [7:0] code, input int len, input logic [7:0] adj,
                           input logic [7:0] endb, input string tag);
    logic [7:0] cnt;
    logic [7:0] sum;
    cnt = 8'(len + 3);
    sum = cnt + code;
    put_stuffed(cnt);
    put_stuffed(code);
    for (int i = 0; i < len; i++) begin
      wq.push_back({8'(i), pl[i]});
      wtag.push_back(tag);
      sum = sum + pl[i];
      put_stuffed(pl[i]);
    end
    if (adj != 8'h00 || endb != 8'h04) eq.push_back({1'b0, 16'h0000});
    else eq.push_back({1'b1, code, 8'(len)});
    etag.push_back(tag);
    put_stuffed(sum + adj);
    put(endb);
  endtask

  task automatic send_pkt(input logic [7:0] code, input int len, input logic [7:0] adj,
                          input logic [7:0] endb, input string tag);
    put(8'h01);
    send_body(code, len, adj, endb, tag);
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (wr_en) begin
        if (wq.size() == 0) chk(1'b0, "R3 unexpected write", {16'h0, wr_addr, wr_data}, 32'h0);
        else begin
          logic [15:0] e;
          string t;
          e = wq.pop_front();
          t = wtag.pop_front();
          chk({wr_addr, wr_data} == e, {t, " write addr/data"}, {16'h0, wr_addr, wr_data}, {16'h0, e});
        end
      end
      if (pkt_done || err) begin
        if (eq.size() == 0) chk(1'b0, "R10 unexpected done/err", {30'h0, pkt_done, err}, 32'h0);
        else begin
          logic [16:0] e;
          logic [16:0] a;
          string t;
          e = eq.pop_front();
          t = etag.pop_front();
          a = pkt_done ? {1'b1, pkt_code, pkt_len} : 17'h0;
          chk((a == e) && (pkt_done != err), {t, " done/err event"}, {15'h0, a}, {15'h0, e});
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en && !pkt_done && !err, "R1 reset outputs", {29'h0, wr_en, pkt_done, err}, 32'h0);
    running = 1'b1;

    // R1: noise while waiting for an opening byte is ignored
    put(8'h04); put(8'h55); put(8'h00);

    // R2/R3: ordinary packet
    for (int i = 0; i < 5; i++) pl[i] = 8'(8'h10 + i * 3);
    send_pkt(8'h42, 5, 8'h00, 8'h04, "R2");

    // R2: empty payload
    send_pkt(8'h7E, 0, 8'h00, 8'h04, "R2 empty");

    // R4: code 0x01, payload 0x01, checksum works out to 0x01
    pl[0] = 8'h01; pl[1] = 8'hFA;
    send_pkt(8'h01, 2, 8'h00, 8'h04, "R4");

    // R6: checksum mismatch, then a good packet
    for (int i = 0; i < 3; i++) pl[i] = 8'(8'hA0 + i);
    send_pkt(8'h11, 3, 8'h01, 8'h04, "R6");
    put(8'h04);
    send_pkt(8'h12, 3, 8'h00, 8'h04, "R6 recovery");

    // R7: wrong closing byte
    send_pkt(8'h13, 3, 8'h00, 8'h07, "R7");

    // R8: short counts, then ignored bytes, then a good packet
    put(8'h01); eq.push_back(17'h0); etag.push_back("R8 count 0"); put(8'h00);
    put(8'h22); put(8'h04);
    put(8'h01); eq.push_back(17'h0); etag.push_back("R8 count 2"); put(8'h02);
    put(8'h01); eq.push_back(17'h0); etag.push_back("R8 count 1"); put_stuffed(8'h01);
    put(8'h33); put(8'h44);
    send_pkt(8'h14, 3, 8'h00, 8'h04, "R8 recovery");

    // R5: lone opening byte abandons a partial packet
    put(8'h01); put(8'h08); put(8'h33);
    wq.push_back({8'h00, 8'hAA}); wtag.push_back("R5 partial");
    put(8'hAA);
    wq.push_back({8'h01, 8'hBB}); wtag.push_back("R5 partial");
    put(8'hBB);
    for (int i = 0; i < 4; i++) pl[i] = 8'(8'h60 + i);
    send_pkt(8'h55, 4, 8'h00, 8'h04, "R5 restart");

    // R9: largest payload
    for (int i = 0; i < 252; i++) pl[i] = 8'(i * 7 + 3);
    send_pkt(8'h99, 252, 8'h00, 8'h04, "R9");

    // R11: idle gaps between bytes
    gap = 3;
    for (int i = 0; i < 6; i++) pl[i] = 8'(8'hC1 + i * 11);
    pl[2] = 8'h01;
    send_pkt(8'h21, 6, 8'h00, 8'h04, "R11");
    gap = 0;

    repeat (5) @(negedge clk);
    chk(wq.size() == 0, "R3 writes pending at end", wq.size(), 0);
    chk(eq.size() == 0, "R2 events pending at end", eq.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule